// File: doc/BRIEF.md
# Two-Stage AND-Gated Switch Sample Filter

This block cleans up a mechanical switch input by sampling it on a slow periodic tick and passing it through two registers. A free-running counter makes a one-cycle tick every `TICK_CYCLES` system clocks. With the default value and a 50 MHz clock, that is one tick every 1.5 ms. The raw switch level first goes through a synchronizer. On each tick, an early register captures the synchronized level. The output register captures the AND of the synchronized level and the early register.

The filter is deliberately asymmetric.

- **High-going pulses:** a high pulse that is present at only one tick never reaches the output, because it must still be high when the next tick comes.
- **Low-going pulses:** a low pulse at a tick pulls the AND to 0 and does reach the output. Once the input is high again, the output returns high within two ticks.

Top module: `sw_gate_filter`

## Requirements
- R1: While `rst_n` is low, `sw_filt` is 0. Releasing reset clears both stages and restarts the tick counter. The release takes effect on the second rising clock edge after `rst_n` goes high.
- R2: A tick occurs every `TICK_CYCLES` clock cycles. Counting the edge on which reset takes effect as edge 0, the stages load on edges `TICK_CYCLES`, `2*TICK_CYCLES`, and so on.
- R3: `sw_raw` passes through `SYNC_STAGES` (default 2) flip-flops before it is used. A stage load uses the value of `sw_raw` that was captured two edges earlier. A change made after that capture edge is not seen until the following tick.
- R4: Both stages hold their values between ticks, so `sw_filt` changes only on a load edge.
- R5: On every tick, the early register takes the synchronized switch level.
- R6: On every tick, the output register takes the synchronized level ANDed with the early register's value from before that tick.
- R7: A high level that is sampled on two consecutive ticks drives `sw_filt` to 1 at the second of those ticks.
- R8: A high level that is sampled at one tick but is low at the next tick never makes `sw_filt` go to 1.
- R9: When `sw_filt` is 1, a low level sampled at a single tick drives `sw_filt` to 0 at that tick.
- R10: After a low glitch has been latched, and once the input is held high again, `sw_filt` returns to 1 no later than the second tick.
- R11: Input activity that starts and ends between two sample points has no effect on either stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sw_raw | input | 1 | Raw, asynchronous switch level |
| sw_filt | output | 1 | Filtered switch level |

## Verification
The assertions rely on the early register and the output register changing only on the cycle after a tick. They also assume the synchronized level is defined from reset onward. This holds because every flop is cleared by the internal reset.

The stimulus changes `sw_raw` only on falling clock edges, and always at a known phase of the bench's own edge count. Because the tick phase is fixed by reset, every sample point the design uses falls at a position the bench can predict. No input change lands near a capture edge unless a test places it there on purpose, as the latency test does.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

  // Contents of the two filter registers.
  typedef struct packed {
    logic early;  // level captured at the last tick
    logic held;   // filtered output level
  } sgf_stage_t;

  // Counter width for a period of n cycles (at least one bit).
  function automatic int unsigned sgf_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sgf_rst_sync.sv
module sgf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d    = {chain_q[STAGES-2:0], 1'b1};
    rst_sync_n = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // R1: the internal reset releases only after the outer reset has been high for a clock.
  p_release_after_outer_r1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> $past(rst_n));

endmodule

// File: rtl/sgf_tick_gen.sv
module sgf_tick_gen
  import sgf_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 75000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CNT_W = sgf_cnt_width(TICK_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the counter never leaves its range.
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2: the tick lasts a single cycle.
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R2: each tick restarts the period.
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/sgf_in_sync.sv
module sgf_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d[0] = din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_shift
    always_comb ff_d[g] = ff_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign dout = ff_q[STAGES-1];

  // R3: the output follows the last flop's input from one cycle before.
  p_chain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (dout == $past(ff_d[STAGES-1])));

endmodule

// File: rtl/sgf_and_stages.sv
module sgf_and_stages
  import sgf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic live,
  output logic filt
);

  sgf_stage_t st_q;
  sgf_stage_t st_d;

  always_comb begin
    st_d.early = live;
    st_d.held  = live & st_q.early;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '0;
    else if (tick) st_q <= st_d;
  end

  assign filt = st_q.held;

  // R4: both stages hold their values between ticks.
  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st_q));

  // R5: the early stage takes the live level at a tick.
  p_early_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (st_q.early == $past(live)));

  // R6: the output loads the live level gated by the early stage.
  p_out_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (filt == ($past(live) && $past(st_q.early))));

  // R8: a rise of the output needs a high early stage before the tick.
  p_rise_needs_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt) |-> ($past(st_q.early) && $past(tick)));

endmodule

// File: rtl/sw_gate_filter.sv
module sw_gate_filter #(
  parameter int unsigned TICK_CYCLES = 75000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_raw,
  output logic sw_filt
);

  logic rst_int_n;
  logic tick;
  logic sw_live;

  sgf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sgf_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  sgf_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (sw_raw),
    .dout  (sw_live)
  );

  sgf_and_stages u_stages (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .live  (sw_live),
    .filt  (sw_filt)
  );

  // R1: the output is low while the outer reset is held.
  p_low_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> !sw_filt);

endmodule

// File: tb/sw_gate_filter_tb_top.sv
module sw_gate_filter_tb_top;

  localparam int N = 8;

  logic clk;
  logic rst_n;
  logic sw_raw;
  logic sw_filt;

  int ecnt;
  int n_checks;
  int n_fail;

  sw_gate_filter #(.TICK_CYCLES(N), .SYNC_STAGES(2), .RST_STAGES(2)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_raw  (sw_raw),
    .sw_filt (sw_filt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Edge count since rst_n rose: load edges are 2 + m*N, m >= 1.
  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_filt=%b expected %b (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  // Wait for the falling edge that follows an edge of the given phase.
  task automatic goto_phase(input int ph);
    do @(negedge clk); while (!(ecnt > N && ((ecnt - 2) % N) == ph));
  endtask

  task automatic wait_edge(input int e);
    do @(negedge clk); while (ecnt != e);
  endtask

  // Present v so that it is the value sampled at the next tick.
  task automatic step(input logic v);
    goto_phase(N - 3);
    sw_raw = v;
    goto_phase(0);
  endtask

  task automatic hold_check(input string req);
    logic ref_v;
    ref_v = sw_filt;
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      check(req, sw_filt, ref_v);
    end
  endtask

  task automatic t_reset_and_period();
    rst_n  = 1'b0;
    sw_raw = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 in reset", sw_filt, 1'b0);
    rst_n = 1'b1;
    wait_edge(N + 2);
    check("R1 first tick clear stage", sw_filt, 1'b0);
    wait_edge(2 * N + 1);
    check("R2 before second tick", sw_filt, 1'b0);
    wait_edge(2 * N + 2);
    check("R2 R7 second tick", sw_filt, 1'b1);
  endtask

  task automatic t_low_glitch();
    step(1'b0);
    check("R9 low glitch latched", sw_filt, 1'b0);
    step(1'b1);
    check("R10 first tick after glitch", sw_filt, 1'b0);
    step(1'b1);
    check("R10 recovered", sw_filt, 1'b1);
  endtask

  task automatic t_sync_latency();
    goto_phase(N - 2);
    sw_raw = 1'b0;
    goto_phase(0);
    check("R3 late change not seen", sw_filt, 1'b1);
    goto_phase(0);
    check("R3 change seen next tick", sw_filt, 1'b0);
    step(1'b0);
    check("R3 settled low", sw_filt, 1'b0);
  endtask

  task automatic t_high_glitch();
    step(1'b1);
    check("R8 single high tick", sw_filt, 1'b0);
    step(1'b0);
    check("R8 glitch gone", sw_filt, 1'b0);
    step(1'b0);
    check("R8 stays low", sw_filt, 1'b0);
  endtask

  task automatic t_two_ticks();
    step(1'b1);
    check("R5 first tick captured only", sw_filt, 1'b0);
    step(1'b1);
    check("R6 R7 two ticks high", sw_filt, 1'b1);
    hold_check("R4 hold high");
  endtask

  task automatic t_between();
    step(1'b0);
    step(1'b0);
    check("R11 setup low", sw_filt, 1'b0);
    sw_raw = 1'b1;
    repeat (3) @(negedge clk);
    sw_raw = 1'b0;
    goto_phase(0);
    check("R11 pulse between ticks ignored", sw_filt, 1'b0);
    hold_check("R4 hold low");
    step(1'b1);
    check("R11 early stage untouched", sw_filt, 1'b0);
    step(1'b1);
    check("R11 R7 rises after two ticks", sw_filt, 1'b1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", sw_filt, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 held in reset", sw_filt, 1'b0);
    rst_n = 1'b1;
    wait_edge(N + 2);
    check("R1 R2 restart first tick", sw_filt, 1'b0);
    wait_edge(2 * N + 2);
    check("R1 R2 restart second tick", sw_filt, 1'b1);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    t_reset_and_period();
    t_low_glitch();
    t_sync_latency();
    t_high_glitch();
    t_two_ticks();
    t_between();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule